// File: doc/BRIEF.md
# FIFO Status Channel Transmitter

This block drives the two-wire out-of-band FIFO status stream of a packet interface in the style of SPI-4.2. While the channel is disabled it holds both wires high. Once enabled it sends a framing word of all ones. It then walks a programmable calendar, one status word per clock. Each calendar slot names a port, and that port's 2-bit FIFO level is placed on the wires. The whole calendar is sent a programmed number of times. A 2-bit diagonal parity code over every status word of the round then closes the round, and a single framing word opens the next one.

The calendar is a register table of slot-to-port entries. Its length and repeat count are given as "minus one" values and are captured once per round. Each port's status is read in the same cycle it goes out on the wires. The channel for the opposite direction is a separate instance, fully independent of this one.

Top module: `fifo_stat_tx`

## Requirements
- R1: After reset, and for as long as enable_i is low, stat_o is 2'b11 on every cycle.
- R2: When enable_i is sampled high at a rising edge while the channel is disabled, stat_o stays 2'b11 for one more cycle (the framing word). The first calendar word appears after the next rising edge.
- R3: A calendar pass sends cal_len_i+1 words in slot order 0,1,2,… Slot i carries the status of port cal_table_i[i*4 +: 4], read from port_stat_i[p*2 +: 2].
- R4: Each round holds cal_rep_i+1 back-to-back calendar passes, followed by exactly one parity word.
- R5: The parity word is computed as follows. An accumulator starts at 2'b00 at the framing word. For each status word w sent, it becomes {acc[0],acc[1]} ^ w. The word sent is the bitwise inverse of the final accumulator.
- R6: After the parity word, exactly one 2'b11 framing word is sent, and then slot 0 of the next round follows.
- R7: If enable_i is sampled low at any rising edge, stat_o is 2'b11 from the next cycle onward. Restarting then goes through the R2 framing sequence.
- R8: cal_len_i and cal_rep_i are captured at the edge that ends the framing word. Changes during a round have no effect until the next round.
- R9: Status encodings are 00 starving, 01 hungry and 10 satisfied. A port that presents the reserved value 11 is sent as 10, so a calendar word is never 11. The value is taken combinationally in the cycle the word is on stat_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Channel enable |
| cal_len_i | input | 4 | Calendar length minus one |
| cal_rep_i | input | 4 | Calendar repetitions minus one |
| cal_table_i | input | 64 | Slot-to-port table, 4 bits per slot, slot 0 in bits 3:0 |
| port_stat_i | input | 32 | Per-port status, 2 bits per port, port 0 in bits 1:0 |
| stat_o | output | 2 | Status lines |

## Verification
The hardest case to reach is a parity word whose value depends on the whole round. This needs many passes over a long calendar while the port levels change every cycle and the length and repeat inputs keep moving mid-round. The stimulus drives random port levels, including the reserved value, on every cycle. It also retunes length and repeat count while a round is in progress, and drops enable at random offsets inside rounds. A behavioural reference model in the bench predicts every word, including each parity word.

// File: rtl/fstx_pkg.sv
package fstx_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_FRAME = 2'd1,
        ST_DATA  = 2'd2,
        ST_PAR   = 2'd3
    } fstx_state_e;

    localparam logic [1:0] FRAME_WORD = 2'b11;
    localparam logic [1:0] SAT_WORD   = 2'b10;

    // one step of the diagonal parity: swap the lanes, then fold in the word
    function automatic logic [1:0] dip_step(input logic [1:0] acc, input logic [1:0] w);
        return {acc[0], acc[1]} ^ w;
    endfunction

endpackage

// File: rtl/fstx_slot_sel.sv
module fstx_slot_sel
    import fstx_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int CAL_SLOTS = 16,
    localparam int PORT_W = $clog2(NUM_PORTS),
    localparam int SLOT_W = $clog2(CAL_SLOTS)
) (
    input  logic [SLOT_W-1:0]           slot_i,
    input  logic [CAL_SLOTS*PORT_W-1:0] table_i,
    input  logic [NUM_PORTS*2-1:0]      stat_i,
    output logic [1:0]                  word_o
);

    logic [PORT_W-1:0] entry [CAL_SLOTS];
    logic [1:0]        level [NUM_PORTS];
    logic [PORT_W-1:0] port_sel;
    logic [1:0]        raw;

    for (genvar g = 0; g < CAL_SLOTS; g++) begin : g_entry
        assign entry[g] = table_i[g*PORT_W +: PORT_W];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_level
        assign level[p] = stat_i[p*2 +: 2];
    end

    always_comb begin
        port_sel = entry[slot_i];
        raw      = (int'(port_sel) < NUM_PORTS) ? level[port_sel] : SAT_WORD;
        word_o   = (raw == FRAME_WORD) ? SAT_WORD : raw;
    end

endmodule

// File: rtl/fstx_ctrl.sv
module fstx_ctrl
    import fstx_pkg::*;
#(
    parameter int CAL_SLOTS = 16,
    parameter int REP_W     = 4,
    localparam int SLOT_W = $clog2(CAL_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [SLOT_W-1:0] len_i,
    input  logic [REP_W-1:0]  rep_i,
    input  logic [1:0]        word_i,
    output fstx_state_e       state_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [1:0]        acc_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CAL_SLOTS - 1);

    typedef struct packed {
        fstx_state_e       state;
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] len;
        logic [REP_W-1:0]  rep;
        logic [REP_W-1:0]  rep_lim;
        logic [1:0]        acc;
    } ctrl_t;

    ctrl_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!en_i) begin
            r_d.state = ST_OFF;
        end else begin
            unique case (r_q.state)
                ST_OFF: r_d.state = ST_FRAME;
                ST_FRAME: begin
                    r_d.state   = ST_DATA;
                    r_d.slot    = '0;
                    r_d.rep     = '0;
                    r_d.acc     = 2'b00;
                    r_d.len     = (len_i > LAST_SLOT) ? LAST_SLOT : len_i;
                    r_d.rep_lim = rep_i;
                end
                ST_DATA: begin
                    r_d.acc = dip_step(r_q.acc, word_i);
                    if (r_q.slot == r_q.len) begin
                        r_d.slot = '0;
                        if (r_q.rep == r_q.rep_lim) r_d.state = ST_PAR;
                        else                        r_d.rep   = r_q.rep + 1'b1;
                    end else begin
                        r_d.slot = r_q.slot + 1'b1;
                    end
                end
                ST_PAR: r_d.state = ST_FRAME;
                default: r_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_OFF, slot: '0, len: '0, rep: '0, rep_lim: '0, acc: 2'b00};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign slot_o  = r_q.slot;
    assign acc_o   = r_q.acc;

    AST_OFF_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> r_q.state == ST_OFF); // R7
    AST_FRAME_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_OFF && en_i) |=> r_q.state == ST_FRAME); // R2
    AST_SINGLE_FRAME_AFTER_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PAR && en_i) |=> (r_q.state == ST_FRAME && r_q.slot == '0)); // R6
    AST_SLOT_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.state == ST_DATA |-> r_q.slot <= r_q.len); // R3
    AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DATA && en_i) |=> $stable(r_q.len)); // R8

endmodule

// File: rtl/fifo_stat_tx.sv
module fifo_stat_tx
    import fstx_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int CAL_SLOTS = 16,
    parameter int REP_W     = 4,
    localparam int PORT_W = $clog2(NUM_PORTS),
    localparam int SLOT_W = $clog2(CAL_SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable_i,
    input  logic [SLOT_W-1:0]           cal_len_i,
    input  logic [REP_W-1:0]            cal_rep_i,
    input  logic [CAL_SLOTS*PORT_W-1:0] cal_table_i,
    input  logic [NUM_PORTS*2-1:0]      port_stat_i,
    output logic [1:0]                  stat_o
);

    fstx_state_e       state;
    logic [SLOT_W-1:0] slot;
    logic [1:0]        acc;
    logic [1:0]        data_word;

    fstx_slot_sel #(
        .NUM_PORTS(NUM_PORTS),
        .CAL_SLOTS(CAL_SLOTS)
    ) u_sel (
        .slot_i (slot),
        .table_i(cal_table_i),
        .stat_i (port_stat_i),
        .word_o (data_word)
    );

    fstx_ctrl #(
        .CAL_SLOTS(CAL_SLOTS),
        .REP_W    (REP_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (enable_i),
        .len_i  (cal_len_i),
        .rep_i  (cal_rep_i),
        .word_i (data_word),
        .state_o(state),
        .slot_o (slot),
        .acc_o  (acc)
    );

    always_comb begin
        unique case (state)
            ST_DATA: stat_o = data_word;
            ST_PAR:  stat_o = ~acc;
            default: stat_o = FRAME_WORD;
        endcase
    end

    AST_DATA_NEVER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DATA |-> stat_o != FRAME_WORD); // R9
    AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> stat_o == FRAME_WORD); // R1

endmodule

// File: tb/tb_fifo_stat_tx.sv
module tb_fifo_stat_tx;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [3:0]  cal_len = '0;
    logic [3:0]  cal_rep = '0;
    logic [63:0] cal_table = '0;
    logic [31:0] port_stat = '0;
    logic [1:0]  stat_o;

    int total = 0;
    int bad = 0;
    string phase = "R1";

    // reference model state
    int m_st = 0;
    int m_slot = 0, m_rep = 0, m_acc = 0, m_len = 0, m_lim = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_stat_tx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable),
        .cal_len_i  (cal_len),
        .cal_rep_i  (cal_rep),
        .cal_table_i(cal_table),
        .port_stat_i(port_stat),
        .stat_o     (stat_o)
    );

    function automatic int slot_word(int s);
        int p, w;
        p = int'(cal_table[s*4 +: 4]);
        w = int'(port_stat[p*2 +: 2]);
        if (w == 3) w = 2;
        return w;
    endfunction

    function automatic int exp_word();
        case (m_st)
            2: return slot_word(m_slot);
            3: return (~m_acc) & 3;
            default: return 3;
        endcase
    endfunction

    function automatic string tag();
        case (m_st)
            0: return "R1/R7";
            1: return "R2/R6";
            2: return "R3/R9";
            default: return "R4/R5";
        endcase
    endfunction

    task automatic check(int exp_v, string req);
        total++;
        if (int'(stat_o) != exp_v) begin
            bad++;
            $display("FAIL %s [%s] stat_o=%0d expected=%0d at %0t", req, phase, stat_o, exp_v, $time);
        end
    endtask

    task automatic model_edge();
        int w;
        if (!rst_n || !enable) begin
            m_st = 0;
        end else begin
            case (m_st)
                0: m_st = 1;
                1: begin
                    m_st = 2; m_slot = 0; m_rep = 0; m_acc = 0;
                    m_len = int'(cal_len); m_lim = int'(cal_rep);
                end
                2: begin
                    w = slot_word(m_slot);
                    m_acc = (((m_acc & 1) << 1) | (m_acc >> 1)) ^ w;
                    if (m_slot == m_len) begin
                        m_slot = 0;
                        if (m_rep == m_lim) m_st = 3;
                        else m_rep++;
                    end else begin
                        m_slot++;
                    end
                end
                default: m_st = 1;
            endcase
        end
    endtask

    // called at a falling edge with inputs settled
    task automatic tick();
        #1;
        check(exp_word(), tag());
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic rand_stat();
        port_stat = $urandom();
    endtask

    task automatic rand_table();
        cal_table = {$urandom(), $urandom()};
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state and disabled idle
        phase = "R1";
        repeat (4) tick();
        rst_n = 1'b1;
        repeat (5) begin rand_stat(); tick(); end

        // R2 R3 R4 R5 R6: four-slot calendar, two passes, moving levels
        phase = "R2 R3 R4 R5 R6";
        rand_table();
        cal_len = 4'd3; cal_rep = 4'd1; enable = 1'b1;
        repeat (60) begin rand_stat(); tick(); end

        // R4: single slot, single pass
        phase = "R4 min";
        enable = 1'b0; tick();
        cal_len = 4'd0; cal_rep = 4'd0; enable = 1'b1;
        repeat (20) begin rand_stat(); tick(); end

        // R3 R5: full calendar, three passes
        phase = "R3 R5 max";
        rand_table(); cal_len = 4'd15; cal_rep = 4'd2;
        repeat (150) begin rand_stat(); tick(); end

        // R8: length and repeat moving every cycle, applied per round only
        phase = "R8";
        repeat (300) begin
            rand_stat();
            cal_len = 4'($urandom_range(0, 15));
            cal_rep = 4'($urandom_range(0, 3));
            tick();
        end

        // R7: enable dropped at random points inside rounds
        phase = "R7";
        cal_len = 4'd5; cal_rep = 4'd1;
        for (int i = 0; i < 25; i++) begin
            enable = 1'b1;
            for (int k = 0; k < int'($urandom_range(1, 30)); k++) begin rand_stat(); tick(); end
            enable = 1'b0;
            repeat (3) begin rand_stat(); tick(); end
        end

        // R9: every port presents the reserved value 11
        phase = "R9";
        port_stat = '1; rand_table(); cal_len = 4'd7; cal_rep = 4'd0;
        enable = 1'b1;
        repeat (30) tick();
        port_stat = 32'h5555_5555;
        repeat (20) tick();

        // R1: back to idle
        phase = "R1 end";
        enable = 1'b0;
        repeat (6) begin rand_stat(); tick(); end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule